// File: doc/BRIEF.md
# Programmable 32-Source Interrupt Controller

This block gathers 32 interrupt request lines into two interrupt outputs, one normal and one critical. Each source has its own sensing mode: edge or level, and active-high or active-low. A captured request is held in a status register. Software clears it by writing a one to its bit. An enable register selects which captured requests may reach an output. A routing register sends each enabled request either to the normal output or to the critical output.

Software uses a word-addressed register port with 32-bit write and read data. Writes are taken on the clock edge while the write strobe is high. Read data is a combinational function of the address. Every per-source register is big-endian in bit order: source n sits at bit 31-n, so source 0 is the most significant bit. Request lines are resynchronised to the block clock before they are sensed.

Top module: `irq_ctl_top`

## Requirements
- R1: After reset, the enable (offset 0x2), critical-route (0x3), polarity (0x4) and trigger (0x5) registers read as zero. The masked status (0x6) reads zero, and both interrupt outputs are low.
- R2: Source n, on input srcIn[n], is mapped to bit 31-n of every per-source register.
- R3: A trigger bit of 0 makes the source level sensitive. Its status bit is set while the input sits at the active level: high when the polarity bit is 1, low when it is 0. This holds even when the source is disabled. A clear has no lasting effect while the level stays active.
- R4: A trigger bit of 1 makes the source edge sensitive. A rising edge sets the status bit when the polarity bit is 1, and a falling edge sets it when the polarity bit is 0. The bit stays set after the input returns, until software clears it.
- R5: In the status register (0x0), writing a 1 to a bit clears it and writing a 0 leaves it as it was. Writing all ones clears every request that is no longer being asserted.
- R6: The masked status register (0x6) reads as status AND enable.
- R7: The normal output is the registered OR of (masked status AND NOT critical route). The critical output is the registered OR of (masked status AND critical route).
- R8: If a new request event and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R9: Offsets 0x1, 0x7, 0x8 and every offset above 0x8 read as zero. Writes to them change no register.
- R10: The enable, critical-route, polarity and trigger registers read back the last value written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcIn | input | 32 | Interrupt request lines; bit n is source n |
| regAddr | input | 4 | Register word offset |
| regWrEn | input | 1 | Write strobe, taken on the rising clock edge |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for regAddr |
| irqNormal | output | 1 | Registered normal interrupt request |
| irqCrit | output | 1 | Registered critical interrupt request |

## Verification
The hardest case to reach from the ports is an edge event and a clear landing on the same status bit in the same clock cycle. The input change has to cross two synchronizer stages before it is seen. The bench changes a request line just after a falling clock edge and then counts two more falling edges. It raises the clear write so that the write is sampled on exactly the edge where the edge detector fires. A follow-up clear with the line idle confirms that the bit stayed set because of the collision, and not because clearing fails.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;

  localparam logic [3:0] OFS_STATUS = 4'h0;
  localparam logic [3:0] OFS_ENABLE = 4'h2;
  localparam logic [3:0] OFS_CRIT   = 4'h3;
  localparam logic [3:0] OFS_POL    = 4'h4;
  localparam logic [3:0] OFS_TRIG   = 4'h5;
  localparam logic [3:0] OFS_MASKED = 4'h6;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_STATUS,
    RD_ENABLE,
    RD_CRIT,
    RD_POL,
    RD_TRIG,
    RD_MASKED
  } rdSel_e;

  typedef struct packed {
    logic   wrStatus;
    logic   wrEnable;
    logic   wrCrit;
    logic   wrPol;
    logic   wrTrig;
    rdSel_e rdSel;
  } ctlStrobe_t;

endpackage

// File: rtl/irq_src_sync.sv
module irq_src_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stageQ [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stageQ[i] <= '0;
    end else begin
      stageQ[0] <= din;
      for (int i = 1; i < STAGES; i++) stageQ[i] <= stageQ[i-1];
    end
  end

  assign dout = stageQ[STAGES-1];

endmodule

// File: rtl/irq_ctl_decode.sv
module irq_ctl_decode
  import irq_ctl_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output ctlStrobe_t        ctl
);

  always_comb begin
    ctl       = '0;
    ctl.rdSel = RD_NONE;
    case (regAddr)
      ADDR_W'(OFS_STATUS): begin ctl.wrStatus = regWrEn; ctl.rdSel = RD_STATUS; end
      ADDR_W'(OFS_ENABLE): begin ctl.wrEnable = regWrEn; ctl.rdSel = RD_ENABLE; end
      ADDR_W'(OFS_CRIT):   begin ctl.wrCrit   = regWrEn; ctl.rdSel = RD_CRIT;   end
      ADDR_W'(OFS_POL):    begin ctl.wrPol    = regWrEn; ctl.rdSel = RD_POL;    end
      ADDR_W'(OFS_TRIG):   begin ctl.wrTrig   = regWrEn; ctl.rdSel = RD_TRIG;   end
      ADDR_W'(OFS_MASKED): begin ctl.rdSel = RD_MASKED; end
      default: ;
    endcase
  end

  AST_ONE_WRITE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.wrStatus, ctl.wrEnable, ctl.wrCrit, ctl.wrPol, ctl.wrTrig})); // R9

  AST_NO_STROBE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !regWrEn |-> !(ctl.wrStatus || ctl.wrEnable || ctl.wrCrit || ctl.wrPol || ctl.wrTrig)); // R9

endmodule

// File: rtl/irq_ctl_datapath.sv
module irq_ctl_datapath
  import irq_ctl_pkg::*;
#(
  parameter int NUM_SRC     = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  ctlStrobe_t         ctl,
  input  logic [NUM_SRC-1:0] wrData,
  output logic [NUM_SRC-1:0] rdData,
  output logic               irqNormal,
  output logic               irqCrit
);

  localparam int MSB = NUM_SRC - 1;

  logic [NUM_SRC-1:0] reqBits;
  logic [NUM_SRC-1:0] syncReq;
  logic [NUM_SRC-1:0] prevQ;
  logic [NUM_SRC-1:0] statusQ, enableQ, critQ, polQ, trigQ;
  logic [NUM_SRC-1:0] actNow, actPrev, evt, clrMask, maskedVal;

  // source n lands on register bit MSB-n
  for (genvar n = 0; n < NUM_SRC; n++) begin : g_bitmap
    assign reqBits[MSB-n] = srcIn[n];
  end

  irq_src_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) sync_i (
    .clk  (clk),
    .rstN (rstN),
    .din  (reqBits),
    .dout (syncReq)
  );

  assign actNow    = ~(syncReq ^ polQ);
  assign actPrev   = ~(prevQ ^ polQ);
  assign evt       = (trigQ & actNow & ~actPrev) | (~trigQ & actNow);
  assign clrMask   = ctl.wrStatus ? wrData : '0;
  assign maskedVal = statusQ & enableQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevQ     <= '0;
      statusQ   <= '0;
      enableQ   <= '0;
      critQ     <= '0;
      polQ      <= '0;
      trigQ     <= '0;
      irqNormal <= 1'b0;
      irqCrit   <= 1'b0;
    end else begin
      prevQ   <= syncReq;
      statusQ <= (statusQ & ~clrMask) | evt;
      if (ctl.wrEnable) enableQ <= wrData;
      if (ctl.wrCrit)   critQ   <= wrData;
      if (ctl.wrPol)    polQ    <= wrData;
      if (ctl.wrTrig)   trigQ   <= wrData;
      irqNormal <= |(maskedVal & ~critQ);
      irqCrit   <= |(maskedVal & critQ);
    end
  end

  always_comb begin
    case (ctl.rdSel)
      RD_STATUS: rdData = statusQ;
      RD_ENABLE: rdData = enableQ;
      RD_CRIT:   rdData = critQ;
      RD_POL:    rdData = polQ;
      RD_TRIG:   rdData = trigQ;
      RD_MASKED: rdData = maskedVal;
      default:   rdData = '0;
    endcase
  end

  AST_LEVEL_REASSERTS: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((statusQ & $past(actNow & ~trigQ)) == $past(actNow & ~trigQ))); // R3

  AST_EDGE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((statusQ & $past(statusQ & trigQ & ~clrMask)) == $past(statusQ & trigQ & ~clrMask))); // R4

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((statusQ & $past(clrMask & ~evt)) == '0)); // R5

  AST_QUIET_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    (enableQ == '0 && $past(enableQ == '0)) |-> (!irqNormal && !irqCrit)); // R7

  AST_COLLISION_SETS: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((statusQ & $past(clrMask & evt)) == $past(clrMask & evt))); // R8

endmodule

// File: rtl/irq_ctl_top.sv
module irq_ctl_top
  import irq_ctl_pkg::*;
#(
  parameter int NUM_SRC     = 32,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               regWrEn,
  input  logic [NUM_SRC-1:0] regWrData,
  output logic [NUM_SRC-1:0] regRdData,
  output logic               irqNormal,
  output logic               irqCrit
);

  ctlStrobe_t ctl;

  irq_ctl_decode #(.ADDR_W(ADDR_W)) decode_i (
    .clk     (clk),
    .rstN    (rstN),
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .ctl     (ctl)
  );

  irq_ctl_datapath #(.NUM_SRC(NUM_SRC), .SYNC_STAGES(SYNC_STAGES)) datapath_i (
    .clk       (clk),
    .rstN      (rstN),
    .srcIn     (srcIn),
    .ctl       (ctl),
    .wrData    (regWrData),
    .rdData    (regRdData),
    .irqNormal (irqNormal),
    .irqCrit   (irqCrit)
  );

endmodule

// File: tb/irq_ctl_top_tb_top.sv
module irq_ctl_top_tb_top;

  localparam time CLK_PERIOD = 10ns;
  localparam logic [3:0] A_STATUS = 4'h0, A_ENABLE = 4'h2, A_CRIT = 4'h3,
                         A_POL = 4'h4, A_TRIG = 4'h5, A_MASKED = 4'h6;
  localparam logic [31:0] ONES = 32'hFFFF_FFFF;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] srcIn = '0;
  logic [3:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        irqNormal, irqCrit;

  int  nChecks = 0;
  int  nErrors = 0;
  bit  done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_ctl_top dut_i (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .irqNormal(irqNormal), .irqCrit(irqCrit)
  );

  function automatic logic [31:0] toRegBits(logic [31:0] pins);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[31-i] = pins[i];
    return r;
  endfunction

  task automatic checkEq(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic waitCyc(int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic wrReg(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic rdCheck(string tag, logic [3:0] a, logic [31:0] exp);
    logic [31:0] d;
    rdReg(a, d);
    checkEq(tag, d, exp);
  endtask

  initial begin
    logic [31:0] d, idle, bitN, stat, expMasked;
    logic [31:0] pat [4];
    logic [31:0] ena [4];
    logic [31:0] crt [4];

    // reset
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(2);
    rdCheck("R1 enable after reset", A_ENABLE, '0);
    rdCheck("R1 crit after reset", A_CRIT, '0);
    rdCheck("R1 polarity after reset", A_POL, '0);
    rdCheck("R1 trigger after reset", A_TRIG, '0);
    rdCheck("R1 masked after reset", A_MASKED, '0);
    checkEq("R1 irqNormal after reset", {31'b0, irqNormal}, 32'd0);
    checkEq("R1 irqCrit after reset", {31'b0, irqCrit}, 32'd0);

    // sweep all four sensing modes over every source
    for (int mode = 0; mode < 4; mode++) begin
      idle = mode[0] ? 32'h0 : ONES;
      srcIn = idle;
      wrReg(A_POL, mode[0] ? ONES : 32'h0);
      wrReg(A_TRIG, mode[1] ? ONES : 32'h0);
      waitCyc(5);
      wrReg(A_STATUS, ONES);
      rdCheck("R5 clear all", A_STATUS, '0);
      for (int n = 0; n < 32; n++) begin
        bitN = 32'h8000_0000 >> n;
        srcIn = idle ^ (32'h1 << n);
        waitCyc(5);
        rdCheck(mode[1] ? "R2 R4 edge capture" : "R2 R3 level capture", A_STATUS, bitN);
        if (!mode[1]) begin
          wrReg(A_STATUS, ONES);
          rdCheck("R3 level clear while active disabled", A_STATUS, bitN);
        end
        srcIn = idle;
        waitCyc(5);
        rdCheck("R4 latched after input returns", A_STATUS, bitN);
        wrReg(A_STATUS, ~bitN);
        rdCheck("R5 zero write no effect", A_STATUS, bitN);
        wrReg(A_STATUS, bitN);
        rdCheck("R5 one write clears", A_STATUS, '0);
      end
    end

    // masking and routing, level active-high
    srcIn = '0;
    wrReg(A_POL, ONES);
    wrReg(A_TRIG, '0);
    waitCyc(5);
    wrReg(A_STATUS, ONES);
    pat[0] = 32'h0000_0001; ena[0] = 32'h8000_0000; crt[0] = 32'h0;
    pat[1] = 32'hF0F0_0000; ena[1] = ONES;          crt[1] = ONES;
    pat[2] = 32'h0000_00FF; ena[2] = 32'h0F00_0000; crt[2] = 32'h0300_0000;
    pat[3] = 32'h1234_5678; ena[3] = 32'h0;         crt[3] = 32'h5555_5555;
    for (int p = 0; p < 4; p++) begin
      srcIn = pat[p];
      waitCyc(5);
      stat = toRegBits(pat[p]);
      rdCheck("R2 status pattern", A_STATUS, stat);
      wrReg(A_ENABLE, ena[p]);
      wrReg(A_CRIT, crt[p]);
      waitCyc(3);
      expMasked = stat & ena[p];
      rdCheck("R6 masked status", A_MASKED, expMasked);
      checkEq("R7 normal output", {31'b0, irqNormal}, {31'b0, |(expMasked & ~crt[p])});
      checkEq("R7 critical output", {31'b0, irqCrit}, {31'b0, |(expMasked & crt[p])});
      srcIn = '0;
      wrReg(A_ENABLE, '0);
      waitCyc(5);
      wrReg(A_STATUS, ONES);
      rdCheck("R5 cleared after pattern", A_STATUS, '0);
    end

    // event and clear in the same cycle, edge rising on source 5
    wrReg(A_TRIG, ONES);
    waitCyc(5);
    wrReg(A_STATUS, ONES);
    @(negedge clk);
    srcIn = 32'h1 << 5;
    @(negedge clk);
    @(negedge clk);
    regAddr = A_STATUS; regWrData = ONES; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
    rdCheck("R8 event wins over clear", A_STATUS, 32'h8000_0000 >> 5);
    wrReg(A_STATUS, ONES);
    rdCheck("R8 later clear works", A_STATUS, '0);

    // register readback
    wrReg(A_ENABLE, 32'hA5A5_0F0F);
    wrReg(A_CRIT, 32'h3C3C_C3C3);
    wrReg(A_POL, 32'h0123_4567);
    wrReg(A_TRIG, 32'hFEDC_BA98);
    rdCheck("R10 enable readback", A_ENABLE, 32'hA5A5_0F0F);
    rdCheck("R10 crit readback", A_CRIT, 32'h3C3C_C3C3);
    rdCheck("R10 polarity readback", A_POL, 32'h0123_4567);
    rdCheck("R10 trigger readback", A_TRIG, 32'hFEDC_BA98);

    // unmapped offsets: edge rising everywhere, one latched bit kept
    wrReg(A_POL, ONES);
    wrReg(A_TRIG, ONES);
    wrReg(A_ENABLE, '0);
    srcIn = '0;
    waitCyc(5);
    wrReg(A_STATUS, ONES);
    srcIn = 32'h1 << 9;
    waitCyc(5);
    for (int a = 0; a < 16; a++) begin
      if (a == 1 || a >= 7) wrReg(4'(a), ONES);
    end
    rdCheck("R9 status untouched", A_STATUS, 32'h8000_0000 >> 9);
    rdCheck("R9 enable untouched", A_ENABLE, '0);
    rdCheck("R9 crit untouched", A_CRIT, 32'h3C3C_C3C3);
    rdCheck("R9 polarity untouched", A_POL, ONES);
    rdCheck("R9 trigger untouched", A_TRIG, ONES);
    for (int a = 0; a < 16; a++) begin
      if (a == 1 || a >= 7) rdCheck("R9 unmapped reads zero", 4'(a), '0);
    end
    checkEq("R9 outputs quiet", {30'b0, irqNormal, irqCrit}, 32'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      nChecks++;
      nErrors++;
      $display("FAIL watchdog R1 actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end

endmodule